// File: doc/BRIEF.md
# Bit-Serial Configuration Loader

This block turns two ordinary input pins into a serial configuration port for a small programmable fabric. While the chip's active-low reset is held low, an external host drives a data line and a strobe line at a leisurely rate. The loader oversamples both lines with the system clock and takes one data bit on each low-to-high transition of the strobe. It assembles the bits into words, most significant bit first, and hands each finished word to the configuration memory together with a word address.

The address counts up from zero each time a loading session starts, one step per finished word. When reset is released, the loader goes quiet. Its bit position and address return to their start values, any bits of an unfinished word are dropped, and the two pins are left to the user design. The strobe is never used as a clock. The system clock must run several times faster than the strobe, and each strobe level must be held for at least two system clock cycles.

Top module: `cfg_bitbang_loader`

## Requirements
- R1: While `rst_n` is high, `word_valid_o` stays low and `word_addr_o` reads 0, whatever `sample_i` and `data_i` do.
- R2: While `rst_n` is low, exactly one data bit is taken per low-to-high transition of `sample_i`. Holding `sample_i` high or low for any number of cycles, or bringing it back low, takes no bit.
- R3: The bit value taken is the level of `data_i` at the strobe's rising transition. Changes on `data_i` while `sample_i` stays high do not alter it.
- R4: Bits fill a word from the most significant end. The first bit taken after a word boundary lands in `word_data_o[WORD_W-1]` and the last in `word_data_o[0]`.
- R5: After the WORD_W-th bit of a word, `word_valid_o` is high for exactly one clock cycle with the complete word on `word_data_o`. Between pulses, `word_data_o` and `word_addr_o` hold their values.
- R6: The first word of each loading session carries address 0, and each later word of the same session carries the previous address plus one.
- R7: Bits of an unfinished word are discarded when `rst_n` goes high. The next session starts a new word at its most significant bit, at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the strobe |
| rst_n | input | 1 | Active-low chip reset; low enables loading |
| sample_i | input | 1 | Bit strobe from the host (shared user input pin 0) |
| data_i | input | 1 | Serial data bit from the host (shared user input pin 1) |
| word_valid_o | output | 1 | One-cycle pulse per completed word |
| word_data_o | output | WORD_W | Completed configuration word |
| word_addr_o | output | ADDR_W | Index of the completed word within the session |

## Verification
On every clock, the assertions check that nothing leaks out while reset is high. They also check that the bit counter only moves on a detected strobe edge, that a word pulse never lasts more than one cycle, and that the word and address outputs stay put between pulses. Only the bench's scenarios show the rest. These are the bit order within a word, data changing during a long strobe-high phase being ignored, addresses counting through a run of words, and a partial word being dropped and the address restarting across a reset release.

// File: rtl/cfg_bitbang_loader.sv
module cfg_bitbang_loader #(
  parameter int WORD_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              data_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [ADDR_W-1:0] word_addr_o
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] strb_sync, dat_sync;
  logic                   strb_prev;
  logic [CNT_W-1:0]       bit_cnt;
  logic [WORD_W-1:0]      shreg;
  logic [ADDR_W-1:0]      next_addr;

  logic loading, strb_edge, bit_in;
  assign loading   = !rst_n;
  assign bit_in    = dat_sync[SYNC_STAGES-1];
  assign strb_edge = strb_sync[SYNC_STAGES-1] && !strb_prev;

  always_ff @(posedge clk) begin
    strb_sync <= {strb_sync[SYNC_STAGES-2:0], sample_i};
    dat_sync  <= {dat_sync[SYNC_STAGES-2:0], data_i};
    strb_prev <= strb_sync[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    word_valid_o <= 1'b0;
    if (!loading) begin
      bit_cnt     <= '0;
      shreg       <= '0;
      next_addr   <= '0;
      word_addr_o <= '0;
      word_data_o <= '0;
    end else if (strb_edge) begin
      shreg   <= {shreg[WORD_W-2:0], bit_in};
      bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      if (bit_cnt == LAST_BIT) begin
        word_valid_o <= 1'b1;
        word_data_o  <= {shreg[WORD_W-2:0], bit_in};
        word_addr_o  <= next_addr;
        next_addr    <= next_addr + 1'b1;
      end
    end
  end

  assert_quiet_out_of_reset_R1: assert property (@(posedge clk)
    rst_n && $past(rst_n) |-> !word_valid_o && word_addr_o == '0);

  assert_count_moves_on_edge_R2: assert property (@(posedge clk) disable iff (rst_n)
    !$past(rst_n) && bit_cnt != $past(bit_cnt) |-> $past(strb_edge));

  assert_single_cycle_pulse_R5: assert property (@(posedge clk) disable iff (rst_n)
    word_valid_o |=> !word_valid_o);

  assert_outputs_hold_between_words_R5: assert property (@(posedge clk) disable iff (rst_n)
    !$past(rst_n) && !word_valid_o |-> $stable(word_data_o) && $stable(word_addr_o));

  assert_count_cleared_on_release_R7: assert property (@(posedge clk)
    rst_n && $past(rst_n) |-> bit_cnt == '0);

endmodule

// File: tb/cfg_bitbang_loader_tb.sv
`timescale 1ns/100ps
module cfg_bitbang_loader_tb_top;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sample_i = 1'b0;
  logic data_i = 1'b0;
  logic              word_valid_o;
  logic [WORD_W-1:0] word_data_o;
  logic [ADDR_W-1:0] word_addr_o;

  int checks = 0;
  int fails = 0;
  logic [WORD_W+ADDR_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  cfg_bitbang_loader #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .data_i(data_i),
    .word_valid_o(word_valid_o), .word_data_o(word_data_o), .word_addr_o(word_addr_o));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one strobe period; long_high keeps the strobe high and wiggles data (R2, R3)
  task automatic send_bit(input bit b, input bit long_high);
    @(negedge clk);
    data_i = b;
    sample_i = 1'b0;
    repeat (4) @(negedge clk);
    sample_i = 1'b1;
    repeat (2) @(negedge clk);
    if (long_high) begin
      for (int k = 0; k < 6; k++) begin
        data_i = ~data_i;
        repeat (3) @(negedge clk);
      end
    end else begin
      repeat (2) @(negedge clk);
    end
    sample_i = 1'b0;
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w, input logic [ADDR_W-1:0] a,
                           input bit long_high);
    exp_q.push_back({a, w});
    for (int i = WORD_W - 1; i >= 0; i--) send_bit(w[i], long_high);
  endtask

  // scoreboard monitor (R4, R5, R6)
  always @(negedge clk) begin
    if (word_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R7 unexpected word", longint'(word_data_o), 0);
      end else begin
        logic [WORD_W+ADDR_W-1:0] e;
        e = exp_q.pop_front();
        check(word_data_o == e[WORD_W-1:0], "R4 word data",
              longint'(word_data_o), longint'(e[WORD_W-1:0]));
        check(word_addr_o == e[WORD_W+ADDR_W-1:WORD_W], "R6 word address",
              longint'(word_addr_o), longint'(e[WORD_W+ADDR_W-1:WORD_W]));
        @(negedge clk);
        check(!word_valid_o, "R5 pulse width", longint'(word_valid_o), 0);
      end
    end
  end

  initial begin
    #750000;
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: pins belong to the user design, nothing emitted
    for (int i = 0; i < 40; i++) send_bit(i[0], 1'b0);
    repeat (4) @(negedge clk);
    check(!word_valid_o, "R1 valid idle", longint'(word_valid_o), 0);
    check(word_addr_o == 0, "R1 addr idle", longint'(word_addr_o), 0);

    // session 1
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    send_word(32'h8000_0001, 8'd0, 1'b0);
    send_word(32'hDEAD_BEEF, 8'd1, 1'b0);
    send_word(32'h1234_5678, 8'd2, 1'b1);
    send_word(32'h0F0F_A5C3, 8'd3, 1'b0);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 0);
    check(word_addr_o == 8'd3, "R5 addr holds", longint'(word_addr_o), 3);
    check(word_data_o == 32'h0F0F_A5C3, "R5 data holds", longint'(word_data_o), 32'h0F0F_A5C3);

    // R7: partial word, then release
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(word_addr_o == 0, "R7 addr cleared", longint'(word_addr_o), 0);
    check(!word_valid_o, "R7 no pulse", longint'(word_valid_o), 0);

    // session 2: fresh word at address 0
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    send_word(32'h0000_0003, 8'd0, 1'b1);
    send_word(32'hFFFF_FFFE, 8'd1, 1'b0);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R7 session two words", exp_q.size(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!word_valid_o && word_addr_o == 0, "R1 after release",
          longint'(word_addr_o), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule